// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side master of a two-wire MDC/MDIO bus. Software uses it to read and write 16-bit registers inside as many as 32 external PHY devices. It has two registers. The configuration/command register holds the PHY address, the register address, a direction flag, a clock-range selector and a busy bit. The data register holds the value to write, or receives the value read back.

Writing the command register with its busy bit set starts one management frame. The block divides the system clock down to MDC and shifts out the whole frame on a tri-state MDIO pin. On reads it captures the PHY's answer. When the frame ends, it clears busy. While busy is set, the register contents are frozen: any register write is dropped and does not disturb the transfer. Between frames, MDC rests low and the MDIO driver is off, so the line floats high on its external pull-up.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, MDC and the MDIO output enable are low, and both register read-back values are zero.
- R2: The command register has this layout: bit 0 busy/go, bit 1 direction (1 = write), bits 3:2 clock range, bits 8:4 register address, bits 13:9 PHY address, bits 15:14 read as zero. An idle write with bit 0 = 0 only stores the fields. An idle write with bit 0 = 1 stores the fields and shows busy = 1 from the next cycle.
- R3: While busy, MDC alternates between a low phase and a high phase, and each phase lasts H = 8 << range system clocks. Every bit period starts with its low phase.
- R4: Every frame starts with 32 one bits, followed by the start pattern 0 then 1, one bit per MDC period.
- R5: The operation code follows the start pattern: 01 for a write, 10 for a read. Then come the 5-bit PHY address and the 5-bit register address, most significant bit first.
- R6: In a write frame, the turnaround bits are driven as 1 then 0, followed by the 16 data register bits, bit 15 first. The output enable stays high for the whole frame.
- R7: In a read frame, the output enable drops at the first turnaround bit (bit 46 of the frame) and stays low to the end of the frame.
- R8: In a read frame, MDIO is sampled on each rising MDC edge of the 16 data bits, with the first sample going to bit 15. The result is loaded into the data register on the cycle busy clears.
- R9: A frame keeps busy high for exactly 64 × 2H cycles. When busy is low, MDC and the output enable are low.
- R10: While busy, writes to either register are dropped. The read-back values do not change and the frame continues unaffected.
- R11: The range field picks the divider. Ranges 0 to 3 give half-periods of 8, 16, 32 and 64 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = data register |
| reg_wdata | input | 16 | Register write value |
| addr_q | output | 16 | Command register read-back (busy in bit 0) |
| data_q | output | 16 | Data register read-back |
| busy | output | 1 | Transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The hardest case to reach is a register write that arrives in the middle of a frame. It must change nothing: not the read-back values, not the shifted bits, and not the data that a read later loads. The stimulus reaches this case by issuing command and data writes about 200 cycles into a running write frame. A behavioural model is compared on every clock, so any leakage into the frame or the registers shows up immediately. A responding PHY model drives the turnaround zero and a chosen value during read data bits. The read frames use ranges 1 and 2, and a final write uses range 3, so the divider choice and the MSB-first capture are both exercised.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int RNG_W     = 2;
  localparam int PRE_LEN   = 32;
  localparam int BASE_HALF = 8;
  localparam int REG_W     = 16;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * PHY_AW;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int FRAME_LEN = DATA_POS + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int HALF_MAX  = BASE_HALF << ((1 << RNG_W) - 1);
  localparam int CNT_W     = $clog2(HALF_MAX) + 1;
  localparam int PAD_W     = REG_W - (2 * PHY_AW + RNG_W + 2);

  typedef logic [FRAME_LEN-1:0] frame_t;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [PHY_AW-1:0] reg_a;
    logic [RNG_W-1:0]  rng;
    logic              wr;
  } cmd_t;

  function automatic int unsigned half_cycles(input logic [RNG_W-1:0] rng);
    return BASE_HALF << rng;
  endfunction

  function automatic frame_t build_frame(input cmd_t c, input logic [DATA_W-1:0] d);
    return {{PRE_LEN{1'b1}}, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.reg_a,
            (c.wr ? 2'b10 : 2'b00), (c.wr ? d : {DATA_W{1'b0}})};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [RNG_W-1:0] rng,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [CNT_W-1:0] cnt;
  logic             phase_end;

  assign phase_end = run && (cnt == CNT_W'(half_cycles(rng) - 1));
  assign rise_ev   = phase_end && !mdc;
  assign fall_ev   = phase_end && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  frame_t frame;

  assign frame   = build_frame(cmd, wdata);
  assign mdio_oe = busy && (cmd.wr || bit_idx < TA_IDX);
  assign mdio_o  = mdio_oe && frame[LAST_IDX - bit_idx];
  assign done    = fall_ev && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      bit_idx <= '0;
    end else if (fall_ev) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rise_ev && !cmd.wr && bit_idx >= DAT_IDX) begin
      rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output cmd_t              cmd,
  output logic              busy,
  output logic [DATA_W-1:0] data_q
);
  logic accept;

  assign accept = reg_wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= '0;
      busy   <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      if (!reg_sel) begin
        cmd  <= cmd_t'(reg_wdata[$bits(cmd_t):1]);
        busy <= reg_wdata[0];
      end else begin
        data_q <= reg_wdata[DATA_W-1:0];
      end
    end else if (done) begin
      busy <= 1'b0;
      if (!cmd.wr) data_q <= rdata;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] addr_q,
  output logic [15:0] data_q,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  cmd_t              cmd;
  logic              rise_ev;
  logic              fall_ev;
  logic              done;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] rdata;

  assign addr_q = {{PAD_W{1'b0}}, cmd, busy};

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .done(done), .rdata(rdata), .cmd(cmd),
    .busy(busy), .data_q(data_q)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .rng(cmd.rng),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd(cmd), .wdata(data_q),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .bit_idx(bit_idx), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rdata(rdata), .done(done)
  );
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic             reg_sel,
  input logic             start_req,
  input logic [15:0]      addr_q,
  input logic [15:0]      data_q,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [IDX_W-1:0] bit_idx
);
  logic       mdc_d;
  logic       busy_d;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d  <= 1'b0;
      busy_d <= 1'b0;
      run    <= '0;
    end else begin
      mdc_d  <= mdc;
      busy_d <= busy;
      if ((mdc != mdc_d) || (busy && !busy_d)) run <= '0;
      else if (run != 8'hFF) run <= run + 1'b1;
    end
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r9_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mdc != mdc_d)) |-> (run == 8'(half_cycles(addr_q[2 +: RNG_W]) - 1)));

  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr_en && !reg_sel && start_req));

  a_r10_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q[15:1]) && $stable(data_q)));

  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr_q[1]) |-> mdio_oe);

  a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !addr_q[1] && bit_idx >= IDX_W'(TA_POS)) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .start_req(reg_wdata[0]), .addr_q(addr_q), .data_q(data_q), .busy(busy),
  .mdc(mdc), .mdio_oe(mdio_oe), .bit_idx(bit_idx)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/100ps
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] addr_q, data_q;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_busy, m_wr;
  logic [4:0]  m_phy, m_ra;
  logic [1:0]  m_rng;
  logic [15:0] m_data, m_cap, phy_val;
  int          m_n;

  always #2.5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .addr_q(addr_q), .data_q(data_q), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic int hp(input logic [1:0] r);
    int h = 8;
    for (int i = 0; i < r; i++) h = h * 2;
    return h;
  endfunction

  function automatic logic [15:0] cmdw(input logic [4:0] phy, input logic [4:0] ra,
                                       input logic [1:0] r, input bit wr, input bit go);
    return {2'b00, phy, ra, r, wr, go};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_phy = '0; m_ra = '0; m_rng = '0;
      m_data = '0; m_cap = '0; m_n = 0;
    end else if (m_busy) begin
      int h;
      h = hp(m_rng);
      if (!m_wr && (m_n / (2 * h)) >= 48 && (m_n % (2 * h)) == h - 1)
        m_cap = {m_cap[14:0], mdio_i};
      m_n++;
      if (m_n == 128 * h) begin
        m_busy = 0;
        if (!m_wr) m_data = m_cap;
      end
    end else if (reg_wr_en) begin
      if (!reg_sel) begin
        m_wr = reg_wdata[1]; m_rng = reg_wdata[3:2];
        m_ra = reg_wdata[8:4]; m_phy = reg_wdata[13:9];
        if (reg_wdata[0]) begin m_busy = 1; m_n = 0; end
      end else begin
        m_data = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int h, k;
      logic [63:0] fr;
      h  = hp(m_rng);
      k  = m_n / (2 * h);
      fr = {32'hFFFF_FFFF, 2'b01, (m_wr ? 2'b01 : 2'b10), m_phy, m_ra, 2'b10, m_data};
      chk("R9 busy", busy, m_busy);
      chk("R3 R11 mdc", mdc, m_busy && ((m_n / h) % 2 == 1));
      chk("R6 R7 oe", mdio_oe, m_busy && (m_wr || k < 46));
      if (m_busy && (m_wr || k < 46))
        chk(k < 34 ? "R4 frame bit" : "R5 R6 frame bit", mdio_o, fr[63 - k]);
      chk("R2 R10 addr readback", addr_q, {2'b00, m_phy, m_ra, m_rng, m_wr, m_busy});
      chk("R8 R10 data readback", data_q, m_data);
      if (m_busy && !m_wr)
        mdio_i = (k == 47) ? 1'b0 : (k >= 48) ? phy_val[63 - k] : 1'b1;
      else
        mdio_i = 1'b1;
    end
  end

  task automatic wr_reg(input logic sel, input logic [15:0] v);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    phy_val = 16'h0000;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", mdio_oe, 0);
    chk("R1 addr", addr_q, 0);
    chk("R1 data", data_q, 0);
    #1 rst_n = 1'b1;

    // R2: store only, no start
    wr_reg(1'b1, 16'hA5C3);
    wr_reg(1'b0, cmdw(5'h13, 5'h0A, 2'd0, 1, 0));
    chk("R2 no start", busy, 0);
    // R2 start of write frame (R4 R5 R6)
    wr_reg(1'b0, cmdw(5'h13, 5'h0A, 2'd0, 1, 1));
    chk("R2 start", busy, 1);
    repeat (200) @(negedge clk);
    // R10: writes during a frame are dropped
    wr_reg(1'b0, cmdw(5'h01, 5'h02, 2'd3, 0, 1));
    wr_reg(1'b1, 16'h1111);
    chk("R10 addr kept", addr_q, cmdw(5'h13, 5'h0A, 2'd0, 1, 1));
    chk("R10 data kept", data_q, 16'hA5C3);
    wait_idle();

    // R7 R8 R11 read with range 1
    phy_val = 16'h3C5A;
    wr_reg(1'b0, cmdw(5'h1F, 5'h00, 2'd1, 0, 1));
    wait_idle();
    chk("R8 read value", data_q, 16'h3C5A);

    // R8 R11 read with range 2, extreme bit pattern
    phy_val = 16'h8001;
    wr_reg(1'b0, cmdw(5'h00, 5'h1F, 2'd2, 0, 1));
    wait_idle();
    chk("R8 read msb lsb", data_q, 16'h8001);

    // R6 R11 write with range 3
    wr_reg(1'b1, 16'h0001);
    wr_reg(1'b0, cmdw(5'h0A, 5'h15, 2'd3, 1, 1));
    wait_idle();
    chk("R9 idle after write", busy, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule